// File: doc/BRIEF.md
# Quadrature Amplitude Fault Monitor

The block watches a pair of signed quadrature samples, one sine and one cosine, and decides on every accepted sample whether the signal amplitude lies in an acceptable range. The result is a single fault flag. It is meant to sit after a sampling front end, where a collapsed or clipped sensor signal must be noticed before position data derived from it is trusted.

Two test methods are available, chosen by a mode bit. The peak method takes the larger of the two absolute sample values and flags a fault when it is under a minimum threshold. The energy method forms the sum of the two squares and flags a fault when it leaves a window bounded by a lower and an upper limit. The window is compared in the squared domain, so no square root is formed. A 2-bit level code picks one of four thresholds for each method. All thresholds are fractions of full scale, where full scale is the largest positive sample value.

Top module: `amp_monitor`

## Requirements
- R1: While `rst_n` is low, `amp_fault` is 0.
- R2: `amp_fault` takes a new value only on a clock edge where `smp_vld` is 1, and that value is visible one cycle later. On any other edge it holds its previous value, whatever the other inputs do.
- R3: With `mode_sel` = 0 (peak method), the fault is 1 exactly when max(|sin|,|cos|) < P[lvl_code]. P = floor(FS*k/100) with k = 60, 64, 68, 72 for codes 0, 1, 2, 3, and FS = 2^(W-1)-1. With W = 12 that gives 1228, 1310, 1391, 1473.
- R4: With `mode_sel` = 1 (energy method), the fault is 1 when sin²+cos² < L², with L = floor(FS*k/100) and k = 20, 30, 40, 50 for codes 0 to 3. With W = 12 that gives 409, 614, 818, 1023.
- R5: With `mode_sel` = 1, the fault is also 1 when sin²+cos² > U², with U = floor(FS*90/100) = 1842 at W = 12, for every level code. Values equal to L² or U² are not faults.
- R6: The most negative sample code, -2^(W-1), is treated as having magnitude FS, in both methods.
- R7: `mode_sel` and `lvl_code` are taken only together with a valid sample. Changing them between strobes does not alter `amp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample pair valid strobe |
| sin_in | input | W | Signed sine sample |
| cos_in | input | W | Signed cosine sample |
| mode_sel | input | 1 | 0 = peak minimum test, 1 = sum-of-squares window test |
| lvl_code | input | 2 | Threshold selection within the active method |
| amp_fault | output | 1 | Registered amplitude fault flag |

## Verification
An internal error shows as a flag that differs from the reference on the cycle after the strobe of the sample concerned. The error may be a wrong threshold constant, a magnitude that wraps on the most negative code, or a squared limit with a truncated width. Each such error is caught only by samples near a boundary, so the sweeps place values one below, at and one above every limit in both methods. A hold fault appears as a flag change on a cycle without a strobe, and the checks between strobes catch it.

// File: rtl/amp_monitor.sv
module amp_monitor #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] sin_in,
  input  logic signed [W-1:0] cos_in,
  input  logic                mode_sel,
  input  logic [1:0]          lvl_code,
  output logic                amp_fault
);
  localparam int  MW  = W - 1;
  localparam int  SQW = 2 * MW + 1;
  localparam longint FS = (longint'(1) << MW) - 1;

  localparam logic [MW-1:0] PK0 = MW'(FS * 60 / 100);
  localparam logic [MW-1:0] PK1 = MW'(FS * 64 / 100);
  localparam logic [MW-1:0] PK2 = MW'(FS * 68 / 100);
  localparam logic [MW-1:0] PK3 = MW'(FS * 72 / 100);

  localparam longint LO0 = FS * 20 / 100;
  localparam longint LO1 = FS * 30 / 100;
  localparam longint LO2 = FS * 40 / 100;
  localparam longint LO3 = FS * 50 / 100;
  localparam longint HI  = FS * 90 / 100;

  localparam logic [SQW-1:0] LO0_SQ = SQW'(LO0 * LO0);
  localparam logic [SQW-1:0] LO1_SQ = SQW'(LO1 * LO1);
  localparam logic [SQW-1:0] LO2_SQ = SQW'(LO2 * LO2);
  localparam logic [SQW-1:0] LO3_SQ = SQW'(LO3 * LO3);
  localparam logic [SQW-1:0] HI_SQ  = SQW'(HI * HI);

  localparam logic [W-1:0]  MOST_NEG = {1'b1, {MW{1'b0}}};
  localparam logic [MW-1:0] MAG_MAX  = {MW{1'b1}};

  logic [W-1:0]   s_neg, c_neg;
  logic [MW-1:0]  s_mag, c_mag, pk_mag, pk_thr;
  logic [SQW-1:0] energy, lo_sq;
  logic           pk_fault, win_fault;

  assign s_neg = -sin_in;
  assign c_neg = -cos_in;

  assign s_mag = !sin_in[W-1] ? sin_in[MW-1:0] :
                 (sin_in == MOST_NEG) ? MAG_MAX : s_neg[MW-1:0];
  assign c_mag = !cos_in[W-1] ? cos_in[MW-1:0] :
                 (cos_in == MOST_NEG) ? MAG_MAX : c_neg[MW-1:0];

  assign pk_mag = (s_mag > c_mag) ? s_mag : c_mag;

  always_comb begin
    unique case (lvl_code)
      2'd0: pk_thr = PK0;
      2'd1: pk_thr = PK1;
      2'd2: pk_thr = PK2;
      default: pk_thr = PK3;
    endcase
  end

  always_comb begin
    unique case (lvl_code)
      2'd0: lo_sq = LO0_SQ;
      2'd1: lo_sq = LO1_SQ;
      2'd2: lo_sq = LO2_SQ;
      default: lo_sq = LO3_SQ;
    endcase
  end

  assign energy = SQW'(s_mag * s_mag) + SQW'(c_mag * c_mag);

  assign pk_fault  = pk_mag < pk_thr;
  assign win_fault = (energy < lo_sq) || (energy > HI_SQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      amp_fault <= 1'b0;
    else if (smp_vld)
      amp_fault <= mode_sel ? win_fault : pk_fault;
  end
endmodule

// File: rtl/amp_monitor_chk.sv
module amp_monitor_chk #(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic signed [W-1:0] sin_in,
  input logic signed [W-1:0] cos_in,
  input logic                mode_sel,
  input logic                amp_fault
);
  localparam logic [W-1:0] POS_FULL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_FULL = {1'b1, {(W-1){1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !amp_fault);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(amp_fault));

  // R3
  zero_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !mode_sel && sin_in == '0 && cos_in == '0 |=> amp_fault);

  // R4
  zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && mode_sel && sin_in == '0 && cos_in == '0 |=> amp_fault);

  // R5
  over_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && mode_sel && sin_in == POS_FULL |=> amp_fault);

  // R6
  neg_full_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !mode_sel && sin_in == NEG_FULL |=> !amp_fault);
endmodule

bind amp_monitor amp_monitor_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sin_in(sin_in),
  .cos_in(cos_in), .mode_sel(mode_sel), .amp_fault(amp_fault)
);

// File: tb/tb_amp_monitor.sv
module tb_amp_monitor;
  localparam int W  = 12;
  localparam int FS = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [W-1:0] sin_in = '0;
  logic signed [W-1:0] cos_in = '0;
  logic mode_sel = 1'b0;
  logic [1:0] lvl_code = 2'd0;
  logic amp_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  amp_monitor #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sin_in(sin_in),
    .cos_in(cos_in), .mode_sel(mode_sel), .lvl_code(lvl_code),
    .amp_fault(amp_fault)
  );

  function automatic int peak_lim(input int code);
    int k[4] = '{60, 64, 68, 72};
    return FS * k[code] / 100;
  endfunction

  function automatic int low_lim(input int code);
    int k[4] = '{20, 30, 40, 50};
    return FS * k[code] / 100;
  endfunction

  function automatic int mag(input int v);
    if (v == -(FS + 1)) return FS;
    return v < 0 ? -v : v;
  endfunction

  function automatic bit ref_fault(input int s, input int c, input bit m, input int code);
    int ms = mag(s);
    int mc = mag(c);
    longint e = longint'(ms) * ms + longint'(mc) * mc;
    longint lo = longint'(low_lim(code)) * low_lim(code);
    longint hi = longint'(FS * 90 / 100) * (FS * 90 / 100);
    if (!m) return ((ms > mc) ? ms : mc) < peak_lim(code);
    return (e < lo) || (e > hi);
  endfunction

  task automatic check(input string req, input bit exp);
    n_chk++;
    if (amp_fault !== exp) begin
      n_bad++;
      $display("FAIL %s: amp_fault=%0b expected=%0b (sin=%0d cos=%0d mode=%0b lvl=%0d)",
               req, amp_fault, exp, sin_in, cos_in, mode_sel, lvl_code);
    end
  endtask

  task automatic apply(input int s, input int c, input bit m, input int code, input string req);
    @(negedge clk);
    sin_in = W'(s); cos_in = W'(c); mode_sel = m; lvl_code = 2'(code); smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    check(req, ref_fault(s, c, m, code));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;

    // R3: peak sweep around each threshold, both signs, either channel
    for (int code = 0; code < 4; code++) begin
      for (int d = -1; d <= 1; d++) begin
        apply(peak_lim(code) + d, 0, 1'b0, code, "R3");
        apply(-3, -(peak_lim(code) + d), 1'b0, code, "R3");
      end
    end
    // R4: lower window edge
    for (int code = 0; code < 4; code++) begin
      for (int d = -1; d <= 1; d++) begin
        apply(low_lim(code) + d, 0, 1'b1, code, "R4");
        apply(0, -(low_lim(code) + d), 1'b1, code, "R4");
      end
    end
    // R5: upper window edge, every code
    for (int code = 0; code < 4; code++) begin
      for (int d = -1; d <= 1; d++)
        apply(FS * 90 / 100 + d, 0, 1'b1, code, "R5");
      apply(1303, 1303, 1'b1, code, "R5");
      apply(1302, 1302, 1'b1, code, "R5");
    end
    // R6: most negative code
    apply(-(FS + 1), 0, 1'b0, 3, "R6");
    apply(-(FS + 1), 0, 1'b1, 0, "R6");
    apply(-(FS + 1), -(FS + 1), 1'b1, 0, "R6");

    // R2 / R7: no strobe, inputs change, flag must hold
    apply(0, 0, 1'b0, 0, "R2");
    held = amp_fault;
    @(negedge clk);
    sin_in = W'(FS); cos_in = '0; mode_sel = 1'b0; lvl_code = 2'd0;
    @(negedge clk);
    check("R2", held);
    mode_sel = 1'b1; lvl_code = 2'd3; sin_in = W'(1000);
    @(negedge clk);
    check("R7", held);
    apply(1000, 0, 1'b0, 0, "R7");
    held = amp_fault;
    mode_sel = 1'b1; lvl_code = 2'd2;
    @(negedge clk);
    check("R7", held);

    // random mix, both methods
    for (int i = 0; i < 3000; i++) begin
      int s = int'($urandom_range(0, 2 * FS + 1)) - (FS + 1);
      int c = int'($urandom_range(0, 2 * FS + 1)) - (FS + 1);
      if (i % 3 == 0) begin
        s = s / 3; c = c / 3;
      end
      apply(s, c, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            (i % 2 == 0) ? "R3/R4/R5 random" : "R2 random");
    end

    // R1 again: reset mid-run clears a set flag
    apply(0, 0, 1'b1, 1, "R4");
    rst_n = 1'b0;
    #1;
    check("R1", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule